// File: doc/BRIEF.md
# Multi-Source Reset Steering Controller

This block collects three reset causes, decides which of three reset domains each cause must reach, and drives one active-low reset per domain. The causes are an active-low battery/real-time-clock reset pin, an active-low reset-switch pin and an active-high watchdog expiry line. The domains are the always-on domain (real-time clock and general-purpose I/O), the peripheral domain and the CPU core. Each cause is synchronised with a chain of flops that clears at once when the cause appears and refills from the clock when it goes away. Each domain reset therefore falls without waiting for a clock edge. It rises on a clock edge only after a programmable hold count.

Software sees one status/control word. Bit 6 is a read/write bit that software sets while SDRAM holds live data. A reset-switch event then reaches the CPU core alone, so the peripheral domain and the memory contents it keeps are left alone. The low bits are sticky cause flags. Hardware sets them and only software clears them. The battery reset puts the whole word back to its initial state and leaves only its own flag set.

Top module: `rst_steer`

## Requirements
- R1: While the battery reset pin is low, all three domain resets are low. Once the domain resets have released, the status word reads 0x01 (bit 0 is the battery-reset flag).
- R2: A reset-switch event with bit 6 clear keeps the always-on reset high, drives the peripheral and CPU resets low, and sets bit 1.
- R3: A reset-switch event with bit 6 set drives only the CPU reset low, keeps the always-on and peripheral resets high, and still sets bit 1.
- R4: A watchdog expiry keeps the always-on reset high and drives the peripheral and CPU resets low whatever the value of bit 6. It sets bit 2.
- R5: A battery reset clears bit 6 and bits 1 and 2, and sets bit 0.
- R6: A set cause flag stays set until software writes 0 to that bit. Writing 1 to a set flag leaves it set.
- R7: Writing 1 to a clear flag bit leaves it clear. Bit 6 reads back the last value written to it.
- R8: A domain reset goes low before the next clock edge after its cause appears. It goes high on exactly the HOLD_CYC+2nd rising edge after the cause is released (default 18).
- R9: When a software clear of a flag and a new event of the same cause fall in the same cycle, the flag ends up set.
- R10: Causes that are active together reset the union of their domains and set every matching flag. A reset-switch cause still active when the battery reset ends also records its flag.
- R11: An asserted always-on reset implies an asserted peripheral reset, and an asserted peripheral reset implies an asserted CPU reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rtc_rst_ni | input | 1 | Battery/real-time-clock reset pin, active low, asynchronous |
| sw_rst_ni | input | 1 | Reset switch, active low, asynchronous |
| wdog_to_i | input | 1 | Watchdog expiry, active high, asynchronous |
| cfg_we_i | input | 1 | Write strobe for the status/control word |
| cfg_wdata_i | input | REG_W | Write data; bit 6 retention, bits 2..0 flag clear-by-zero |
| cfg_rdata_o | output | REG_W | Status/control word; bit 0 battery, bit 1 switch, bit 2 watchdog, bit 6 retention |
| aon_rst_no | output | 1 | Always-on domain reset, active low |
| per_rst_no | output | 1 | Peripheral domain reset, active low |
| cpu_rst_no | output | 1 | CPU core reset, active low |

## Verification
The two functions that can land in the same cycle are the software write that clears the cause flags and a hardware event that sets one of them. The bench holds the reset switch low so that the switch cause is asserted on every edge. It then issues a write of zero to the flag bits. The scoreboard expects bit 1 to read back as set, which shows that the set has priority. After the switch is released, the same write must clear the flag. The scoreboard compares this against a separately computed expected word.

// File: rtl/rst_steer_pkg.sv
package rst_steer_pkg;

   localparam int SRC_N   = 3;
   localparam int SRC_BAT = 0;
   localparam int SRC_SW  = 1;
   localparam int SRC_WD  = 2;

   localparam int DOM_N   = 3;
   localparam int DOM_AON = 0;
   localparam int DOM_PER = 1;
   localparam int DOM_CPU = 2;

   localparam int KEEP_BIT = 6;

   typedef logic [SRC_N-1:0] src_vec_t;
   typedef logic [DOM_N-1:0] dom_vec_t;

   localparam src_vec_t SRC_ACT_HIGH = 3'b100;

endpackage

// File: rtl/rst_src_sync.sv
module rst_src_sync #(
   parameter int STAGES      = 2,
   parameter bit ACTIVE_HIGH = 1'b0
) (
   input  logic clk,
   input  logic src_i,
   output logic act_o
);

   logic [STAGES-1:0] shf_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rst_src_sync: STAGES must be at least 2");
      end

      if (ACTIVE_HIGH) begin : g_hi
         always_ff @(posedge clk or posedge src_i) begin
            if (src_i) shf_q <= '0;
            else       shf_q <= {shf_q[STAGES-2:0], 1'b1};
         end
      end else begin : g_lo
         always_ff @(posedge clk or negedge src_i) begin
            if (!src_i) shf_q <= '0;
            else        shf_q <= {shf_q[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   assign act_o = ~shf_q[STAGES-1];

endmodule

// File: rtl/rst_dom_hold.sv
module rst_dom_hold #(
   parameter int HOLD_CYC = 16
) (
   input  logic clk,
   input  logic req_i,
   output logic rst_no
);

   localparam int CW = $clog2(HOLD_CYC + 1) + 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("rst_dom_hold: HOLD_CYC must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge req_i) begin
      if (req_i) begin
         cnt_q  <= '0;
         rst_no <= 1'b0;
      end else if (cnt_q != LAST) begin
         cnt_q  <= cnt_q + 1'b1;
      end else begin
         rst_no <= 1'b1;
      end
   end

   // Checker-side run length of quiet cycles with the reset still low.
   logic [CW-1:0] quiet_q;
   always_ff @(posedge clk or posedge req_i) begin
      if (req_i)                              quiet_q <= '0;
      else if (!rst_no && quiet_q != '1)      quiet_q <= quiet_q + 1'b1;
   end

   p_min_hold_r8: assert property (@(posedge clk) disable iff (req_i)
      $rose(rst_no) |-> (quiet_q >= CW'(HOLD_CYC)));

   p_req_holds_low_r8: assert property (@(posedge clk)
      req_i |-> !rst_no);

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rst_steer_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_ni,
   input  src_vec_t         set_i,
   input  logic             we_i,
   input  logic [REG_W-1:0] wdata_i,
   output src_vec_t         flags_o,
   output logic             keep_o
);

   src_vec_t flags_d;

   generate
      if (REG_W <= KEEP_BIT) begin : g_bad_width
         $error("rst_cause_reg: REG_W too narrow for the retention bit");
      end
   endgenerate

   always_comb begin
      flags_d = flags_o;
      for (int i = 0; i < SRC_N; i++) begin
         if (we_i && !wdata_i[i]) flags_d[i] = 1'b0;
         if (set_i[i])            flags_d[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_o          <= '0;
         flags_o[SRC_BAT] <= 1'b1;
         keep_o           <= 1'b0;
      end else begin
         flags_o <= flags_d;
         if (we_i) keep_o <= wdata_i[KEEP_BIT];
      end
   end

   p_sticky_sw_r6: assert property (@(posedge clk) disable iff (!rst_ni)
      (flags_o[SRC_SW] && !we_i) |=> flags_o[SRC_SW]);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_ni)
      set_i[SRC_SW] |=> flags_o[SRC_SW]);

   p_keep_rw_r7: assert property (@(posedge clk) disable iff (!rst_ni)
      we_i |=> (keep_o == $past(wdata_i[KEEP_BIT])));

endmodule

// File: rtl/rst_steer.sv
module rst_steer
   import rst_steer_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 16,
   parameter int REG_W       = 8
) (
   input  logic             clk,
   input  logic             rtc_rst_ni,
   input  logic             sw_rst_ni,
   input  logic             wdog_to_i,
   input  logic             cfg_we_i,
   input  logic [REG_W-1:0] cfg_wdata_i,
   output logic [REG_W-1:0] cfg_rdata_o,
   output logic             aon_rst_no,
   output logic             per_rst_no,
   output logic             cpu_rst_no
);

   src_vec_t src_raw;
   src_vec_t act;
   src_vec_t flags;
   dom_vec_t dom_req;
   dom_vec_t dom_rst_n;
   logic     keep;
   logic     core_rst_n;

   assign src_raw[SRC_BAT] = rtc_rst_ni;
   assign src_raw[SRC_SW]  = sw_rst_ni;
   assign src_raw[SRC_WD]  = wdog_to_i;

   generate
      for (genvar s = 0; s < SRC_N; s++) begin : g_sync
         rst_src_sync #(
            .STAGES      (SYNC_STAGES),
            .ACTIVE_HIGH (SRC_ACT_HIGH[s])
         ) u_sync (
            .clk   (clk),
            .src_i (src_raw[s]),
            .act_o (act[s])
         );
      end
   endgenerate

   assign core_rst_n = ~act[SRC_BAT];

   rst_cause_reg #(.REG_W(REG_W)) u_cause (
      .clk     (clk),
      .rst_ni  (core_rst_n),
      .set_i   (act),
      .we_i    (cfg_we_i),
      .wdata_i (cfg_wdata_i),
      .flags_o (flags),
      .keep_o  (keep)
   );

   // Scope per domain: the battery reset reaches everything, the watchdog
   // spares the always-on domain, the switch also spares peripherals when
   // retention is requested.
   always_comb begin
      dom_req[DOM_AON] = act[SRC_BAT];
      dom_req[DOM_PER] = act[SRC_BAT] | act[SRC_WD] | (act[SRC_SW] & ~keep);
      dom_req[DOM_CPU] = |act;
   end

   generate
      for (genvar d = 0; d < DOM_N; d++) begin : g_dom
         rst_dom_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
            .clk    (clk),
            .req_i  (dom_req[d]),
            .rst_no (dom_rst_n[d])
         );
      end
   endgenerate

   assign aon_rst_no = dom_rst_n[DOM_AON];
   assign per_rst_no = dom_rst_n[DOM_PER];
   assign cpu_rst_no = dom_rst_n[DOM_CPU];

   always_comb begin
      cfg_rdata_o           = '0;
      cfg_rdata_o[SRC_N-1:0] = flags;
      cfg_rdata_o[KEEP_BIT] = keep;
   end

   p_nest_aon_per_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
      !aon_rst_no |-> !per_rst_no);

   p_nest_per_cpu_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
      !per_rst_no |-> !cpu_rst_no);

   p_wdog_spares_aon_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
      $rose(act[SRC_WD]) |-> aon_rst_no);

   p_keep_spares_per_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
      (act[SRC_SW] && keep && !act[SRC_WD] && per_rst_no) |=> per_rst_no);

endmodule

// File: tb/rst_steer_bench.sv
module rst_steer_bench;

   localparam int HOLD  = 16;
   localparam int REG_W = 8;

   logic             clk = 1'b0;
   logic             rtc_rst_ni = 1'b1;
   logic             sw_rst_ni  = 1'b1;
   logic             wdog_to_i  = 1'b0;
   logic             cfg_we_i   = 1'b0;
   logic [REG_W-1:0] cfg_wdata_i = '0;
   logic [REG_W-1:0] cfg_rdata_o;
   logic             aon_rst_no, per_rst_no, cpu_rst_no;

   int checks   = 0;
   int failures = 0;

   always #4 clk = ~clk;

   rst_steer #(.SYNC_STAGES(2), .HOLD_CYC(HOLD), .REG_W(REG_W)) u_rst_steer (
      .clk         (clk),
      .rtc_rst_ni  (rtc_rst_ni),
      .sw_rst_ni   (sw_rst_ni),
      .wdog_to_i   (wdog_to_i),
      .cfg_we_i    (cfg_we_i),
      .cfg_wdata_i (cfg_wdata_i),
      .cfg_rdata_o (cfg_rdata_o),
      .aon_rst_no  (aon_rst_no),
      .per_rst_no  (per_rst_no),
      .cpu_rst_no  (cpu_rst_no)
   );

   typedef struct {
      string      tag;
      logic [7:0] rd;
      logic [2:0] rst;   // {cpu, per, aon}, active low
   } exp_t;

   exp_t exp_q[$];

   // Monitor: compares each queued expectation at the next falling edge.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         logic [2:0] got;
         e   = exp_q.pop_front();
         got = {cpu_rst_no, per_rst_no, aon_rst_no};
         checks++;
         if (cfg_rdata_o !== e.rd || got !== e.rst) begin
            failures++;
            $display("FAIL %s: rd=%h rst=%b expected rd=%h rst=%b",
                     e.tag, cfg_rdata_o, got, e.rd, e.rst);
         end
      end
   end

   task automatic expect_state(input string tag, input logic [7:0] rd,
                               input logic aon, input logic per, input logic cpu);
      exp_t e;
      e.tag = tag;
      e.rd  = rd;
      e.rst = {cpu, per, aon};
      exp_q.push_back(e);
      @(negedge clk);
      #1;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      cfg_we_i    = 1'b1;
      cfg_wdata_i = v;
      @(posedge clk);
      #1;
      cfg_we_i    = 1'b0;
   endtask

   // Counts rising edges from a release (done by the caller just after an
   // edge) to the rise of the CPU reset; the always-on reset is checked too.
   task automatic measure(input string tag, input logic aon_exp);
      int n = 0;
      while (n < 60) begin
         @(posedge clk);
         #1;
         n++;
         if (cpu_rst_no) break;
      end
      checks++;
      if (n != HOLD + 2 || aon_rst_no !== aon_exp) begin
         failures++;
         $display("FAIL %s: release edges=%0d aon=%b expected edges=%0d aon=%b",
                  tag, n, aon_rst_no, HOLD + 2, aon_exp);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : driver
      #1 rtc_rst_ni = 1'b0;
      cycles(6);
      expect_state("R1 battery reset holds all domains", 8'h01, 0, 0, 0);
      @(posedge clk); #1 rtc_rst_ni = 1'b1;
      measure("R8 battery release timing", 1'b1);
      expect_state("R1 after battery release", 8'h01, 1, 1, 1);

      wr(8'h00);
      expect_state("R6 software clears battery flag", 8'h00, 1, 1, 1);
      wr(8'h07);
      expect_state("R7 writing ones does not set flags", 8'h00, 1, 1, 1);
      wr(8'h40);
      expect_state("R7 retention bit reads back", 8'h40, 1, 1, 1);
      wr(8'h00);

      // R2: switch without retention
      @(posedge clk); #1 sw_rst_ni = 1'b0;
      expect_state("R8 asynchronous assertion before edge", 8'h00, 1, 0, 0);
      cycles(3);
      expect_state("R2 switch resets peripherals and core", 8'h02, 1, 0, 0);
      @(posedge clk); #1 sw_rst_ni = 1'b1;
      measure("R8 switch release timing", 1'b1);
      expect_state("R2 after switch release", 8'h02, 1, 1, 1);
      cycles(10);
      expect_state("R6 flag stays set", 8'h02, 1, 1, 1);
      wr(8'h02);
      expect_state("R6 writing one keeps flag", 8'h02, 1, 1, 1);
      wr(8'h00);

      // R3: switch with retention
      wr(8'h40);
      @(posedge clk); #1 sw_rst_ni = 1'b0;
      cycles(3);
      expect_state("R3 retention keeps peripherals", 8'h42, 1, 1, 0);
      @(posedge clk); #1 sw_rst_ni = 1'b1;
      cycles(25);
      expect_state("R3 after release", 8'h42, 1, 1, 1);

      // R4: watchdog ignores retention
      wr(8'h40);
      @(posedge clk); #1 wdog_to_i = 1'b1;
      cycles(2);
      expect_state("R4 watchdog resets peripherals and core", 8'h44, 1, 0, 0);
      @(posedge clk); #1 wdog_to_i = 1'b0;
      measure("R8 watchdog release timing", 1'b1);
      expect_state("R4 after watchdog release", 8'h44, 1, 1, 1);

      // R10: switch and watchdog together with retention set
      wr(8'h40);
      @(posedge clk); #1 sw_rst_ni = 1'b0; wdog_to_i = 1'b1;
      cycles(3);
      expect_state("R10 union of scopes and flags", 8'h46, 1, 0, 0);
      @(posedge clk); #1 sw_rst_ni = 1'b1; wdog_to_i = 1'b0;
      cycles(25);

      // R9: clear and set in the same cycle
      wr(8'h40);
      expect_state("R9 flags cleared before test", 8'h40, 1, 1, 1);
      @(posedge clk); #1 sw_rst_ni = 1'b0;
      cycles(3);
      wr(8'h40);
      expect_state("R9 set wins over clear", 8'h42, 1, 1, 0);
      @(posedge clk); #1 sw_rst_ni = 1'b1;
      cycles(25);
      wr(8'h40);
      expect_state("R9 clear works once cause is gone", 8'h40, 1, 1, 1);

      // R5: battery reset wipes retention and other flags
      @(posedge clk); #1 wdog_to_i = 1'b1;
      cycles(3);
      @(posedge clk); #1 wdog_to_i = 1'b0;
      cycles(25);
      expect_state("R5 flags before battery reset", 8'h44, 1, 1, 1);
      @(posedge clk); #1 rtc_rst_ni = 1'b0;
      cycles(3);
      expect_state("R5 battery reset clears word", 8'h01, 0, 0, 0);
      @(posedge clk); #1 rtc_rst_ni = 1'b1;
      cycles(25);
      expect_state("R5 after battery release", 8'h01, 1, 1, 1);

      // R10: switch outlasting a battery reset records its flag
      @(posedge clk); #1 rtc_rst_ni = 1'b0; sw_rst_ni = 1'b0;
      cycles(3);
      expect_state("R11 nested scopes during battery reset", 8'h01, 0, 0, 0);
      @(posedge clk); #1 rtc_rst_ni = 1'b1;
      cycles(25);
      expect_state("R10 switch flag recorded after battery", 8'h03, 1, 0, 0);
      @(posedge clk); #1 sw_rst_ni = 1'b1;
      cycles(25);
      expect_state("R10 all released", 8'h03, 1, 1, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule